// File: doc/BRIEF.md
# Bus Window Decoder with Per-Target Address Translation

This block fans one Wishbone initiator port out to several target ports. Each target owns a fixed, power-of-two sized, naturally aligned window of the initiator's word address space. The window's base and size are set by elaboration parameters. Purely combinational logic picks the target whose window holds the current address. Only that target sees its cycle line raised. The block hands it the address with the window base removed, and it returns that target's read data and response lines to the initiator.

Each target is built in one of three mapping modes. A dense target has the full data width and the same select granularity as the initiator. A fine target has half the initiator's granularity: its select bits come in pairs, its address gains one low bit, and its window therefore covers half as many initiator words as its address width would give. A sparse target is narrower than a data lane: each of its words sits in the lowest lane of one initiator word, and the upper lanes read as zero. The other request lines are copied to every target whether or not it is selected: strobe, write enable, write data, lock, cycle type and burst type.

An initiator that addresses a hole in the map gets no response from this block, so it must detect the hole with its own timeout.

Top module: `wbx_decoder`

## Requirements
- R1: A target's `o_s_cyc` bit is high only while `i_cyc` is high and `i_adr` lies inside that target's window; at most one bit is ever high.
- R2: `o_s_stb`, `o_s_we`, `o_s_dat_w`, `o_s_lock`, `o_s_cti` and `o_s_bte` equal the matching initiator inputs at all times, regardless of selection.
- R3: For a dense target (mode 0), the target address is `i_adr` minus the window base, and the target select equals `i_sel` zero-extended.
- R4: For a fine target (mode 1), the target address is (offset << 1) | lane, where lane is 1 only when the lower half of `i_sel` is zero and the upper half is not. Initiator select bit j drives target select bits 2j and 2j+1. The window spans 2^(AW-1) initiator words.
- R5: For a sparse target (mode 2), the target address is the offset and the target select is `i_sel[0]` alone in bit 0. `o_dat_r` carries the target's low SDW data bits, with all higher bits zero.
- R6: `o_ack` and `o_stall` copy the selected target's `i_s_ack` and `i_s_stall` bits; other targets' bits have no effect.
- R7: `o_err` and `o_rty` copy the selected target's bits only if that target is configured as having them; otherwise they are 0.
- R8: While `i_cyc` is low, no `o_s_cyc` bit is set and `o_dat_r`, `o_ack`, `o_err`, `o_rty`, `o_stall` are all 0.
- R9: With `i_cyc` high and an address in no window, no `o_s_cyc` bit is set and `o_dat_r`, `o_ack`, `o_err`, `o_rty`, `o_stall` are all 0.
- R10: For dense and fine targets, `o_dat_r` equals the selected target's full read word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_cyc | input | 1 | Initiator cycle |
| i_stb | input | 1 | Initiator strobe |
| i_we | input | 1 | Initiator write enable |
| i_adr | input | ADDR_W | Initiator word address |
| i_sel | input | DATA_W/GRAN | Initiator lane selects |
| i_dat_w | input | DATA_W | Initiator write data |
| i_lock | input | 1 | Initiator lock |
| i_cti | input | 3 | Initiator cycle type |
| i_bte | input | 2 | Initiator burst type |
| o_dat_r | output | DATA_W | Read data to initiator |
| o_ack | output | 1 | Acknowledge to initiator |
| o_err | output | 1 | Error to initiator |
| o_rty | output | 1 | Retry to initiator |
| o_stall | output | 1 | Stall to initiator |
| o_s_cyc | output | N_SUB | Per-target cycle |
| o_s_stb | output | 1 | Strobe copied to all targets |
| o_s_we | output | 1 | Write enable copied to all targets |
| o_s_adr | output | N_SUB*SUB_AW_MAX | Per-target translated address |
| o_s_sel | output | N_SUB*2*DATA_W/GRAN | Per-target translated selects |
| o_s_dat_w | output | DATA_W | Write data copied to all targets |
| o_s_lock | output | 1 | Lock copied to all targets |
| o_s_cti | output | 3 | Cycle type copied to all targets |
| o_s_bte | output | 2 | Burst type copied to all targets |
| i_s_dat_r | input | N_SUB*DATA_W | Per-target read data |
| i_s_ack | input | N_SUB | Per-target acknowledge |
| i_s_err | input | N_SUB | Per-target error |
| i_s_rty | input | N_SUB | Per-target retry |
| i_s_stall | input | N_SUB | Per-target stall |

## Verification
The whole 12-bit address space is walked with the cycle line high, once for each of the four select patterns. This reaches every window edge, every hole and the word just past each window. It separates a wrong base compare from a wrong window size, and it catches a lane bit or select expansion that goes wrong only for one select value. The modelled targets return data computed from the address they actually receive, so a translation fault shows up in the read data as well as on the address port. The per-target response bits change with the address, so a response taken from the wrong target, or an error or retry from a target that lacks it, appears within a few steps. A second sweep with the cycle line low shows that nothing is selected or returned while the bus is idle.

// File: rtl/wbx_pkg.sv
package wbx_pkg;
   localparam int MAP_DENSE  = 0;
   localparam int MAP_FINE   = 1;
   localparam int MAP_SPARSE = 2;
   localparam int CTI_W = 3;
   localparam int BTE_W = 2;

   // number of initiator address bits covered by one window
   function automatic int win_bits(input int mode, input int aw);
      return (mode == MAP_FINE) ? aw - 1 : aw;
   endfunction

   function automatic bit legal_width(input int w);
      return (w == 8) || (w == 16) || (w == 32) || (w == 64);
   endfunction
endpackage

// File: rtl/wbx_window.sv
module wbx_window
   import wbx_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int SEL_W  = 2,
   parameter int SAW    = 8,
   parameter logic [ADDR_W-1:0] BASE = '0,
   parameter int AW     = 7,
   parameter int MODE   = MAP_DENSE,
   parameter int SDW    = 32
) (
   input  logic                i_cyc,
   input  logic [ADDR_W-1:0]   i_adr,
   input  logic [SEL_W-1:0]    i_sel,
   input  logic [DATA_W-1:0]   i_dat_r,
   output logic                o_hit,
   output logic [SAW-1:0]      o_adr,
   output logic [2*SEL_W-1:0]  o_sel,
   output logic [DATA_W-1:0]   o_dat_r
);
   localparam int WB  = win_bits(MODE, AW);
   localparam int SSW = 2 * SEL_W;

   logic [WB-1:0] offset;

   assign offset = i_adr[WB-1:0];
   assign o_hit  = i_cyc && (i_adr[ADDR_W-1:WB] == BASE[ADDR_W-1:WB]);

   generate
      if (MODE == MAP_FINE) begin : g_fine
         localparam int HS = SEL_W / 2;
         logic lane;
         assign lane  = (i_sel[HS-1:0] == '0) && (i_sel[SEL_W-1:HS] != '0);
         assign o_adr = SAW'({offset, lane});
         for (genvar j = 0; j < SEL_W; j++) begin : g_dup
            assign o_sel[2*j +: 2] = {2{i_sel[j]}};
         end
         assign o_dat_r = i_dat_r;
      end else if (MODE == MAP_SPARSE) begin : g_sparse
         logic unused_bits;
         assign unused_bits = ^{i_sel, i_dat_r};
         assign o_adr   = SAW'(offset);
         assign o_sel   = SSW'(i_sel[0]);
         assign o_dat_r = DATA_W'(i_dat_r[SDW-1:0]);
      end else begin : g_dense
         assign o_adr   = SAW'(offset);
         assign o_sel   = SSW'(i_sel);
         assign o_dat_r = i_dat_r;
      end
   endgenerate
endmodule

// File: rtl/wbx_resp_mux.sv
module wbx_resp_mux #(
   parameter int N_SUB  = 4,
   parameter int DATA_W = 32,
   parameter logic [N_SUB-1:0] HAS_ERR = '0,
   parameter logic [N_SUB-1:0] HAS_RTY = '0
) (
   input  logic [N_SUB-1:0]        i_hit,
   input  logic [N_SUB*DATA_W-1:0] i_dat,
   input  logic [N_SUB-1:0]        i_ack,
   input  logic [N_SUB-1:0]        i_err,
   input  logic [N_SUB-1:0]        i_rty,
   input  logic [N_SUB-1:0]        i_stall,
   output logic [DATA_W-1:0]       o_dat,
   output logic                    o_ack,
   output logic                    o_err,
   output logic                    o_rty,
   output logic                    o_stall
);
   // windows are disjoint, so an AND-OR tree is a full multiplexer
   always_comb begin
      o_dat = '0;
      for (int k = 0; k < N_SUB; k++) begin
         o_dat = o_dat | ({DATA_W{i_hit[k]}} & i_dat[k*DATA_W +: DATA_W]);
      end
   end

   assign o_ack   = |(i_hit & i_ack);
   assign o_stall = |(i_hit & i_stall);
   assign o_err   = |(i_hit & i_err & HAS_ERR);
   assign o_rty   = |(i_hit & i_rty & HAS_RTY);
endmodule

// File: rtl/wbx_decoder.sv
module wbx_decoder
   import wbx_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int GRAN       = 16,
   parameter int N_SUB      = 4,
   parameter int SUB_AW_MAX = 8,
   parameter logic [N_SUB*ADDR_W-1:0] SUB_BASE = {12'h400, 12'h300, 12'h200, 12'h100},
   parameter logic [N_SUB*8-1:0]      SUB_AW   = {8'd8, 8'd8, 8'd6, 8'd7},
   parameter logic [N_SUB*2-1:0]      SUB_MODE = {2'd2, 2'd2, 2'd1, 2'd0},
   parameter logic [N_SUB*8-1:0]      SUB_DW   = {8'd8, 8'd16, 8'd32, 8'd32},
   parameter logic [N_SUB-1:0]        SUB_HAS_ERR = 4'b0110,
   parameter logic [N_SUB-1:0]        SUB_HAS_RTY = 4'b1010
) (
   input  logic                                 i_cyc,
   input  logic                                 i_stb,
   input  logic                                 i_we,
   input  logic [ADDR_W-1:0]                    i_adr,
   input  logic [DATA_W/GRAN-1:0]               i_sel,
   input  logic [DATA_W-1:0]                    i_dat_w,
   input  logic                                 i_lock,
   input  logic [2:0]                           i_cti,
   input  logic [1:0]                           i_bte,
   output logic [DATA_W-1:0]                    o_dat_r,
   output logic                                 o_ack,
   output logic                                 o_err,
   output logic                                 o_rty,
   output logic                                 o_stall,
   output logic [N_SUB-1:0]                     o_s_cyc,
   output logic                                 o_s_stb,
   output logic                                 o_s_we,
   output logic [N_SUB*SUB_AW_MAX-1:0]          o_s_adr,
   output logic [N_SUB*2*(DATA_W/GRAN)-1:0]     o_s_sel,
   output logic [DATA_W-1:0]                    o_s_dat_w,
   output logic                                 o_s_lock,
   output logic [2:0]                           o_s_cti,
   output logic [1:0]                           o_s_bte,
   input  logic [N_SUB*DATA_W-1:0]              i_s_dat_r,
   input  logic [N_SUB-1:0]                     i_s_ack,
   input  logic [N_SUB-1:0]                     i_s_err,
   input  logic [N_SUB-1:0]                     i_s_rty,
   input  logic [N_SUB-1:0]                     i_s_stall
);
   localparam int SEL_W = DATA_W / GRAN;
   localparam int SSW   = 2 * SEL_W;

   // elaboration-time parameter checks
   if (!legal_width(DATA_W) || !legal_width(GRAN) || GRAN > DATA_W) begin : g_bad_width
      $error("wbx_decoder: illegal data width or granularity");
   end
   if (ADDR_W > 31) begin : g_bad_aw
      $error("wbx_decoder: address width too large");
   end

   logic [N_SUB-1:0]        hit;
   logic [N_SUB*DATA_W-1:0] xdat;

   generate
      for (genvar k = 0; k < N_SUB; k++) begin : g_sub
         localparam int MD = int'(SUB_MODE[k*2 +: 2]);
         localparam int AW = int'(SUB_AW[k*8 +: 8]);
         localparam int DW = int'(SUB_DW[k*8 +: 8]);
         localparam int WB = win_bits(MD, AW);
         localparam int BI = int'(SUB_BASE[k*ADDR_W +: ADDR_W]);

         if (AW > SUB_AW_MAX || WB < 1 || WB >= ADDR_W) begin : g_bad_size
            $error("wbx_decoder: window size out of range");
         end
         if ((BI % (1 << WB)) != 0) begin : g_bad_align
            $error("wbx_decoder: window base not aligned to its size");
         end
         if (MD == MAP_FINE && (GRAN < 16 || (SEL_W % 2) != 0 || DW != DATA_W)) begin : g_bad_fine
            $error("wbx_decoder: fine mapping needs even select width and full data");
         end
         if (MD == MAP_SPARSE && (!legal_width(DW) || DW > GRAN)) begin : g_bad_sparse
            $error("wbx_decoder: sparse target width must match its granularity and fit a lane");
         end
         if (MD == MAP_DENSE && DW != DATA_W) begin : g_bad_dense
            $error("wbx_decoder: dense target must have full data width");
         end
         if (MD > MAP_SPARSE) begin : g_bad_mode
            $error("wbx_decoder: unknown mapping mode");
         end
         for (genvar m = k + 1; m < N_SUB; m++) begin : g_ovl
            localparam int WO = win_bits(int'(SUB_MODE[m*2 +: 2]), int'(SUB_AW[m*8 +: 8]));
            localparam int WM = (WO > WB) ? WO : WB;
            localparam int BO = int'(SUB_BASE[m*ADDR_W +: ADDR_W]);
            if ((BI >> WM) == (BO >> WM)) begin : g_overlap
               $error("wbx_decoder: target windows overlap");
            end
         end

         wbx_window #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .SEL_W  (SEL_W),
            .SAW    (SUB_AW_MAX),
            .BASE   (SUB_BASE[k*ADDR_W +: ADDR_W]),
            .AW     (AW),
            .MODE   (MD),
            .SDW    (DW)
         ) u_win (
            .i_cyc   (i_cyc),
            .i_adr   (i_adr),
            .i_sel   (i_sel),
            .i_dat_r (i_s_dat_r[k*DATA_W +: DATA_W]),
            .o_hit   (hit[k]),
            .o_adr   (o_s_adr[k*SUB_AW_MAX +: SUB_AW_MAX]),
            .o_sel   (o_s_sel[k*SSW +: SSW]),
            .o_dat_r (xdat[k*DATA_W +: DATA_W])
         );
      end
   endgenerate

   assign o_s_cyc   = hit;
   assign o_s_stb   = i_stb;
   assign o_s_we    = i_we;
   assign o_s_dat_w = i_dat_w;
   assign o_s_lock  = i_lock;
   assign o_s_cti   = i_cti;
   assign o_s_bte   = i_bte;

   wbx_resp_mux #(
      .N_SUB   (N_SUB),
      .DATA_W  (DATA_W),
      .HAS_ERR (SUB_HAS_ERR),
      .HAS_RTY (SUB_HAS_RTY)
   ) u_mux (
      .i_hit   (hit),
      .i_dat   (xdat),
      .i_ack   (i_s_ack),
      .i_err   (i_s_err),
      .i_rty   (i_s_rty),
      .i_stall (i_s_stall),
      .o_dat   (o_dat_r),
      .o_ack   (o_ack),
      .o_err   (o_err),
      .o_rty   (o_rty),
      .o_stall (o_stall)
   );
endmodule

// File: rtl/wbx_decoder_chk.sv
module wbx_decoder_chk #(
   parameter int N_SUB  = 4,
   parameter int DATA_W = 32
) (
   input logic              i_cyc,
   input logic [N_SUB-1:0]  o_s_cyc,
   input logic [DATA_W-1:0] o_dat_r,
   input logic              o_ack,
   input logic              o_err,
   input logic              o_rty,
   input logic              o_stall,
   input logic [N_SUB-1:0]  i_s_ack,
   input logic [N_SUB-1:0]  i_s_err,
   input logic [N_SUB-1:0]  i_s_stall
);
   always_comb begin
      AST_ONE_TARGET: assert ($onehot0(o_s_cyc)) else $error("more than one target selected"); // R1
      if (!i_cyc) begin
         AST_IDLE_QUIET: assert (o_s_cyc == '0 && o_dat_r == '0 && !o_ack && !o_err && !o_rty && !o_stall)
            else $error("activity while idle"); // R8
      end
      if (i_cyc && o_s_cyc == '0) begin
         AST_HOLE_QUIET: assert (o_dat_r == '0 && !o_ack && !o_err && !o_rty && !o_stall)
            else $error("response from unmapped address"); // R9
      end
      AST_ACK_SOURCE: assert (o_ack == |(o_s_cyc & i_s_ack)) else $error("ack not from selected target"); // R6
      AST_STALL_SOURCE: assert (o_stall == |(o_s_cyc & i_s_stall)) else $error("stall not from selected target"); // R6
      if (o_err) begin
         AST_ERR_SOURCE: assert (|(o_s_cyc & i_s_err)) else $error("error not from selected target"); // R7
      end
   end
endmodule

bind wbx_decoder wbx_decoder_chk #(.N_SUB(N_SUB), .DATA_W(DATA_W)) u_chk (
   .i_cyc     (i_cyc),
   .o_s_cyc   (o_s_cyc),
   .o_dat_r   (o_dat_r),
   .o_ack     (o_ack),
   .o_err     (o_err),
   .o_rty     (o_rty),
   .o_stall   (o_stall),
   .i_s_ack   (i_s_ack),
   .i_s_err   (i_s_err),
   .i_s_stall (i_s_stall)
);

// File: tb/wbx_decoder_bench.sv
module wbx_decoder_bench;
   localparam logic [3:0] HAS_ERR = 4'b0110;
   localparam logic [3:0] HAS_RTY = 4'b1010;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic        i_cyc = 1'b0, i_stb = 1'b0, i_we = 1'b0, i_lock = 1'b0;
   logic [11:0] i_adr = '0;
   logic [1:0]  i_sel = '0;
   logic [31:0] i_dat_w = '0;
   logic [2:0]  i_cti = '0;
   logic [1:0]  i_bte = '0;
   logic [3:0]  i_s_ack = '0, i_s_err = '0, i_s_rty = '0, i_s_stall = '0;
   logic [127:0] i_s_dat_r;

   logic [31:0] o_dat_r, o_s_dat_w;
   logic        o_ack, o_err, o_rty, o_stall, o_s_stb, o_s_we, o_s_lock;
   logic [3:0]  o_s_cyc;
   logic [31:0] o_s_adr;
   logic [15:0] o_s_sel;
   logic [2:0]  o_s_cti;
   logic [1:0]  o_s_bte;

   int n_chk = 0;
   int n_fail = 0;

   wbx_decoder u_wbx_decoder (
      .i_cyc(i_cyc), .i_stb(i_stb), .i_we(i_we), .i_adr(i_adr), .i_sel(i_sel),
      .i_dat_w(i_dat_w), .i_lock(i_lock), .i_cti(i_cti), .i_bte(i_bte),
      .o_dat_r(o_dat_r), .o_ack(o_ack), .o_err(o_err), .o_rty(o_rty), .o_stall(o_stall),
      .o_s_cyc(o_s_cyc), .o_s_stb(o_s_stb), .o_s_we(o_s_we), .o_s_adr(o_s_adr),
      .o_s_sel(o_s_sel), .o_s_dat_w(o_s_dat_w), .o_s_lock(o_s_lock), .o_s_cti(o_s_cti),
      .o_s_bte(o_s_bte), .i_s_dat_r(i_s_dat_r), .i_s_ack(i_s_ack), .i_s_err(i_s_err),
      .i_s_rty(i_s_rty), .i_s_stall(i_s_stall)
   );

   function automatic logic [31:0] tgt_word(input int k, input logic [7:0] a);
      logic [15:0] low;
      low = 16'(int'(a) * 7 + k);
      return {4'(k), 4'h5, a, low};
   endfunction

   // modelled targets answer from the address they actually receive
   for (genvar k = 0; k < 4; k++) begin : g_tgt
      assign i_s_dat_r[k*32 +: 32] = tgt_word(k, o_s_adr[k*8 +: 8]);
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s adr=%h sel=%b cyc=%b act=%h exp=%h", req, what, i_adr, i_sel, i_cyc, act, exp);
      end
   endtask

   task automatic apply_and_check(input logic cyc, input logic [11:0] adr, input logic [1:0] sel);
      int k;
      int off;
      logic [7:0]  eadr;
      logic [3:0]  esel;
      logic [31:0] edat;
      @(negedge clk);
      i_cyc = cyc; i_adr = adr; i_sel = sel;
      i_stb = adr[0] ^ sel[0]; i_we = adr[1]; i_lock = adr[2];
      i_cti = adr[5:3]; i_bte = adr[7:6];
      i_dat_w = (32'(adr) * 32'h9E3779B1) ^ 32'(sel);
      i_s_ack = adr[3:0]; i_s_err = adr[7:4]; i_s_rty = ~adr[3:0];
      i_s_stall = adr[11:8] ^ adr[3:0];
      #5;
      k = -1; off = 0; eadr = '0; esel = '0; edat = '0;
      if (cyc) begin
         if (adr >= 12'h100 && adr < 12'h180) begin k = 0; off = int'(adr) - 'h100; end
         else if (adr >= 12'h200 && adr < 12'h220) begin k = 1; off = int'(adr) - 'h200; end
         else if (adr >= 12'h300 && adr < 12'h400) begin k = 2; off = int'(adr) - 'h300; end
         else if (adr >= 12'h400 && adr < 12'h500) begin k = 3; off = int'(adr) - 'h400; end
      end
      // R2: copied lines
      chk("R2", "stb", 64'(o_s_stb), 64'(i_stb));
      chk("R2", "we/lock/cti/bte", {o_s_we, o_s_lock, o_s_cti, o_s_bte}, {i_we, i_lock, i_cti, i_bte});
      chk("R2", "dat_w", 64'(o_s_dat_w), 64'(i_dat_w));
      // R1: cycle routing
      chk("R1", "s_cyc", 64'(o_s_cyc), (k >= 0) ? 64'(4'b1 << k) : 64'(0));
      if (k == 0) begin
         eadr = 8'(off); esel = {2'b00, sel}; edat = tgt_word(0, eadr);
         chk("R3", "dense adr", 64'(o_s_adr[7:0]), 64'(eadr));
         chk("R3", "dense sel", 64'(o_s_sel[3:0]), 64'(esel));
         chk("R10", "dense dat_r", 64'(o_dat_r), 64'(edat));
      end else if (k == 1) begin
         eadr = 8'((off << 1) | ((sel == 2'b10) ? 1 : 0));
         esel = {sel[1], sel[1], sel[0], sel[0]}; edat = tgt_word(1, eadr);
         chk("R4", "fine adr", 64'(o_s_adr[15:8]), 64'(eadr));
         chk("R4", "fine sel", 64'(o_s_sel[7:4]), 64'(esel));
         chk("R10", "fine dat_r", 64'(o_dat_r), 64'(edat));
      end else if (k >= 2) begin
         eadr = 8'(off); esel = {3'b000, sel[0]};
         edat = tgt_word(k, eadr);
         edat = (k == 2) ? {16'h0, edat[15:0]} : {24'h0, edat[7:0]};
         chk("R5", "sparse adr", 64'(o_s_adr[k*8 +: 8]), 64'(eadr));
         chk("R5", "sparse sel", 64'(o_s_sel[k*4 +: 4]), 64'(esel));
         chk("R5", "sparse dat_r", 64'(o_dat_r), 64'(edat));
      end
      if (k >= 0) begin
         chk("R6", "ack/stall", {o_ack, o_stall}, {i_s_ack[k], i_s_stall[k]});
         chk("R7", "err/rty", {o_err, o_rty}, {i_s_err[k] & HAS_ERR[k], i_s_rty[k] & HAS_RTY[k]});
      end else if (cyc) begin
         chk("R9", "hole response", {o_dat_r, o_ack, o_err, o_rty, o_stall}, 64'(0));
      end else begin
         chk("R8", "idle response", {o_dat_r, o_ack, o_err, o_rty, o_stall}, 64'(0));
      end
   endtask

   initial begin
      repeat (4) @(posedge clk);
      rst = 1'b0;
      @(negedge clk); #5;
      // R8: state after reset with all inputs low
      chk("R8", "reset s_cyc", 64'(o_s_cyc), 64'(0));
      chk("R8", "reset response", {o_dat_r, o_ack, o_err, o_rty, o_stall}, 64'(0));
      for (int s = 0; s < 4; s++) begin
         for (int a = 0; a < 4096; a++) begin
            apply_and_check(1'b1, 12'(a), 2'(s));
         end
      end
      for (int a = 0; a < 4096; a += 7) begin
         apply_and_check(1'b0, 12'(a), 2'(a));
      end
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule